// File: doc/BRIEF.md
# Character Bank and Mirroring Decoder

This block turns the control registers of a cartridge banking controller into the eight 1 KB page numbers that address the pattern-table area of character memory. It also produces the 2-bit nametable mirroring code. Whenever the surrounding register file reports that one of its registers has been written, through a one-cycle update pulse and a 2-bit register index, the block takes the current register contents. It then recomputes only the outputs that this register controls. Program banking and the memories are handled elsewhere.

Character memory is banked in one of two ways. A split bit from the control register selects between them. With the split bit set, the lower and upper 4 KB halves are banked independently by two bank registers. With it clear, one 8 KB unit is taken from the lower bank register. Each bank number is scaled by four and expanded into consecutive 1 KB pages. ROM pages wrap at the ROM page count. When the cartridge carries character RAM instead of ROM, the upper half can be pointed at RAM pages without wrapping, and a flag tells the memory side to route those four pages to RAM.

Only the control-register bits this block uses are brought in: the two mirroring bits and the split bit. The bank registers come in at full width.

Top module: `chr_page_mapper`

## Requirements
- R1: Out of reset, page slot k holds page k for k = 0..7, the upper-half RAM flag is 0, and the mirroring code is the decode of the reset mirroring bits (default 2'b00, giving code 3).
- R2: On an update with index 0, the mirroring code becomes 0 for mirroring bits 2'b11, 1 for 2'b10, 2 for 2'b01 and 3 for 2'b00. Updates with any other index leave the mirroring code unchanged.
- R3: On an index-1 update with character ROM, a nonzero page count N and the split bit set, slot k (k = 0..3) becomes (lo_bank*4 + k) mod N. Slots 4..7 and the RAM flag are unchanged.
- R4: On an index-1 update with character ROM, a nonzero N and the split bit clear, slot k (k = 0..7) becomes (lo_bank*4 + k) mod N, and the RAM flag clears.
- R5: On an index-2 update with character ROM, a nonzero N and the split bit set, slot 4+k (k = 0..3) becomes (hi_bank*4 + k) mod N, and the RAM flag clears.
- R6: On an index-2 update in character-RAM mode with the split bit set, slot 4+k becomes hi_bank*4 + k with no wrap, and the RAM flag sets.
- R7: An index-2 update with the split bit clear changes no page slot and not the RAM flag.
- R8: An index-1 update in character-RAM mode changes no page slot and not the RAM flag.
- R9: With character ROM and a page count of 0, index-1 and index-2 updates leave all page slots and the RAM flag unchanged.
- R10: Outputs change only on the clock edge that samples the update pulse. Cycles without a pulse, and pulses with index 3, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_valid | input | 1 | One-cycle pulse: a register was written |
| upd_sel | input | 2 | Index of the written register (0 control, 1 lower bank, 2 upper bank, 3 other) |
| ctrl_mirror_sel | input | 2 | Mirroring bits of the control register |
| ctrl_split_chr | input | 1 | Control split bit: 1 = two 4 KB halves, 0 = one 8 KB unit |
| lo_bank_reg | input | REG_W | Lower (or whole 8 KB) bank register |
| hi_bank_reg | input | REG_W | Upper-half bank register |
| chr_page_count | input | PAGE_W+1 | Number of 1 KB character-ROM pages (0 = none usable) |
| chr_ram_mode | input | 1 | 1 = character RAM present instead of ROM |
| chr_page | output | 8 x PAGE_W | Page number per 1 KB slot, slot k in element k |
| hi_ram_sel | output | 1 | Upper four slots address character RAM |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A wrong page slot or mirroring register is visible at the ports on the negative edge right after the update that should have set it. The page outputs are the stored state itself, so no hidden state can stay wrong without showing. The bench sweeps every bank value against several page counts, including 1, non-powers of two, the full count and zero, in both split modes and both memory kinds. Every update is followed by a comparison of all eight slots, the RAM flag and the mirroring code. A slot that should have held but was overwritten is therefore caught as quickly as one that failed to load.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  localparam int unsigned PAGE_SLOTS = 8;
  localparam int unsigned HALF_SLOTS = PAGE_SLOTS / 2;

  // register index carried with the update pulse
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_LO   = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;

  typedef enum logic [1:0] {
    MIR_PAIR_H   = 2'd0,
    MIR_PAIR_V   = 2'd1,
    MIR_SINGLE_B = 2'd2,
    MIR_SINGLE_A = 2'd3
  } mirror_t;

  function automatic mirror_t mirror_code(input logic [1:0] sel);
    mirror_t code;
    case (sel)
      2'b11:   code = MIR_PAIR_H;
      2'b10:   code = MIR_PAIR_V;
      2'b01:   code = MIR_SINGLE_B;
      default: code = MIR_SINGLE_A;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/chr_mirror_decode.sv
module chr_mirror_decode
  import chr_map_pkg::*;
(
  input  logic [1:0] mirror_sel,
  output logic [1:0] mirror_code_o
);

  always_comb begin
    mirror_code_o = mirror_code(mirror_sel);
  end

endmodule

// File: rtl/chr_page_calc.sv
// One page slot: bank*4 + OFFSET, optionally wrapped by the page count.
module chr_page_calc #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned CNT_W  = PAGE_W + 1,
  parameter int unsigned OFFSET = 0
) (
  input  logic [REG_W-1:0]  bank,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output logic [PAGE_W-1:0] page
);

  localparam int unsigned RAW_W = REG_W + 3;
  localparam int unsigned WW    = (RAW_W > CNT_W) ? RAW_W : CNT_W;

  logic [WW-1:0] raw;
  logic [WW-1:0] wrapped;

  always_comb begin
    raw = WW'({bank, 2'b00}) + WW'(OFFSET);
    if (count == '0) begin
      wrapped = raw;
    end else begin
      wrapped = raw % WW'(count);
    end
    page = wrap ? PAGE_W'(wrapped) : PAGE_W'(raw);
  end

endmodule

// File: rtl/chr_rst_sync.sv
module chr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/chr_page_mapper.sv
module chr_page_mapper
  import chr_map_pkg::*;
#(
  parameter int unsigned REG_W            = 5,
  parameter int unsigned PAGE_W           = 8,
  parameter logic [1:0]  MIRROR_SEL_RESET = 2'b00
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  upd_valid,
  input  logic [1:0]                            upd_sel,
  input  logic [1:0]                            ctrl_mirror_sel,
  input  logic                                  ctrl_split_chr,
  input  logic [REG_W-1:0]                      lo_bank_reg,
  input  logic [REG_W-1:0]                      hi_bank_reg,
  input  logic [PAGE_W:0]                       chr_page_count,
  input  logic                                  chr_ram_mode,
  output logic [PAGE_SLOTS-1:0][PAGE_W-1:0]     chr_page,
  output logic                                  hi_ram_sel,
  output logic [1:0]                            mirror_mode
);

  localparam int unsigned CNT_W = PAGE_W + 1;

  logic                                  rst_sync_n;
  logic [PAGE_SLOTS-1:0][PAGE_W-1:0]     lo_val;
  logic [HALF_SLOTS-1:0][PAGE_W-1:0]     hi_val;
  logic [1:0]                            mir_dec;
  logic                                  count_ok;

  logic [PAGE_SLOTS-1:0][PAGE_W-1:0]     page_d;
  logic                                  hi_ram_d;
  logic [1:0]                            mirror_d;
  logic                                  state_en;

  chr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  chr_mirror_decode u_mirror (
    .mirror_sel    (ctrl_mirror_sel),
    .mirror_code_o (mir_dec)
  );

  // lower bank register feeds every slot (8 KB mode uses all eight)
  for (genvar i = 0; i < PAGE_SLOTS; i++) begin : g_lo
    chr_page_calc #(
      .REG_W (REG_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .OFFSET(i)
    ) u_calc (
      .bank  (lo_bank_reg),
      .count (chr_page_count),
      .wrap  (1'b1),
      .page  (lo_val[i])
    );
  end

  // upper bank register feeds the upper half; RAM pages are not wrapped
  for (genvar j = 0; j < HALF_SLOTS; j++) begin : g_hi
    chr_page_calc #(
      .REG_W (REG_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .OFFSET(j)
    ) u_calc (
      .bank  (hi_bank_reg),
      .count (chr_page_count),
      .wrap  (!chr_ram_mode),
      .page  (hi_val[j])
    );
  end

  assign count_ok = (chr_page_count != '0);
  assign state_en = upd_valid;

  // next-state
  always_comb begin
    page_d   = chr_page;
    hi_ram_d = hi_ram_sel;
    mirror_d = mirror_mode;
    case (upd_sel)
      SEL_CTRL: begin
        mirror_d = mir_dec;
      end
      SEL_LO: begin
        if (!chr_ram_mode && count_ok) begin
          for (int i = 0; i < PAGE_SLOTS; i++) begin
            if ((i < HALF_SLOTS) || !ctrl_split_chr) begin
              page_d[i] = lo_val[i];
            end
          end
          if (!ctrl_split_chr) begin
            hi_ram_d = 1'b0;
          end
        end
      end
      SEL_HI: begin
        if (ctrl_split_chr) begin
          if (chr_ram_mode) begin
            for (int j = 0; j < HALF_SLOTS; j++) begin
              page_d[HALF_SLOTS + j] = hi_val[j];
            end
            hi_ram_d = 1'b1;
          end else if (count_ok) begin
            for (int j = 0; j < HALF_SLOTS; j++) begin
              page_d[HALF_SLOTS + j] = hi_val[j];
            end
            hi_ram_d = 1'b0;
          end
        end
      end
      default: begin
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < PAGE_SLOTS; i++) begin
        chr_page[i] <= PAGE_W'(i);
      end
      hi_ram_sel  <= 1'b0;
      mirror_mode <= mirror_code(MIRROR_SEL_RESET);
    end else if (state_en) begin
      chr_page    <= page_d;
      hi_ram_sel  <= hi_ram_d;
      mirror_mode <= mirror_d;
    end
  end

endmodule

// File: rtl/chr_page_mapper_chk.sv
module chr_page_mapper_chk #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned SLOTS  = 8
) (
  input logic                          clk,
  input logic                          rst_sync_n,
  input logic                          upd_valid,
  input logic [1:0]                    upd_sel,
  input logic [1:0]                    ctrl_mirror_sel,
  input logic                          ctrl_split_chr,
  input logic [PAGE_W:0]               chr_page_count,
  input logic                          chr_ram_mode,
  input logic [SLOTS-1:0][PAGE_W-1:0]  chr_page,
  input logic                          hi_ram_sel,
  input logic [1:0]                    mirror_mode
);

  localparam int unsigned HALF = SLOTS / 2;

  a_r2_mirror_decode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel == 2'd0) |=>
      (mirror_mode == {~$past(ctrl_mirror_sel[1]), ~$past(ctrl_mirror_sel[0])}));

  a_r2_mirror_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel != 2'd0) |=> $stable(mirror_mode));

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel == 2'd1 && ctrl_split_chr) |=>
      ($stable(chr_page[SLOTS-1:HALF]) && $stable(hi_ram_sel)));

  a_r5_rom_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel == 2'd2 && ctrl_split_chr && !chr_ram_mode &&
     chr_page_count != '0) |=>
      (({1'b0, chr_page[HALF]} < $past(chr_page_count)) && !hi_ram_sel));

  a_r6_ram_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel == 2'd2 && ctrl_split_chr && chr_ram_mode) |=> hi_ram_sel);

  a_r7_hi_no_split: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel == 2'd2 && !ctrl_split_chr) |=>
      ($stable(chr_page) && $stable(hi_ram_sel)));

  a_r8_ram_lo_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && upd_sel == 2'd1 && chr_ram_mode) |=>
      ($stable(chr_page) && $stable(hi_ram_sel)));

  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && (upd_sel == 2'd1 || upd_sel == 2'd2) && !chr_ram_mode &&
     chr_page_count == '0) |=> ($stable(chr_page) && $stable(hi_ram_sel)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!upd_valid || upd_sel == 2'd3) |=>
      ($stable(chr_page) && $stable(hi_ram_sel) && $stable(mirror_mode)));

endmodule

bind chr_page_mapper chr_page_mapper_chk #(
  .PAGE_W (PAGE_W),
  .SLOTS  (chr_map_pkg::PAGE_SLOTS)
) u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .upd_valid       (upd_valid),
  .upd_sel         (upd_sel),
  .ctrl_mirror_sel (ctrl_mirror_sel),
  .ctrl_split_chr  (ctrl_split_chr),
  .chr_page_count  (chr_page_count),
  .chr_ram_mode    (chr_ram_mode),
  .chr_page        (chr_page),
  .hi_ram_sel      (hi_ram_sel),
  .mirror_mode     (mirror_mode)
);

// File: tb/chr_page_mapper_tb_top.sv
module chr_page_mapper_tb_top;

  localparam int REG_W  = 5;
  localparam int PAGE_W = 8;

  logic                    clk;
  logic                    rst_n;
  logic                    upd_valid;
  logic [1:0]              upd_sel;
  logic [1:0]              ctrl_mirror_sel;
  logic                    ctrl_split_chr;
  logic [REG_W-1:0]        lo_bank_reg;
  logic [REG_W-1:0]        hi_bank_reg;
  logic [PAGE_W:0]         chr_page_count;
  logic                    chr_ram_mode;
  logic [7:0][PAGE_W-1:0]  chr_page;
  logic                    hi_ram_sel;
  logic [1:0]              mirror_mode;

  int checks;
  int errors;
  bit done;

  int exp_pg [8];
  bit exp_hi;
  int exp_mir;

  chr_page_mapper #(.REG_W(REG_W), .PAGE_W(PAGE_W)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .upd_valid       (upd_valid),
    .upd_sel         (upd_sel),
    .ctrl_mirror_sel (ctrl_mirror_sel),
    .ctrl_split_chr  (ctrl_split_chr),
    .lo_bank_reg     (lo_bank_reg),
    .hi_bank_reg     (hi_bank_reg),
    .chr_page_count  (chr_page_count),
    .chr_ram_mode    (chr_ram_mode),
    .chr_page        (chr_page),
    .hi_ram_sel      (hi_ram_sel),
    .mirror_mode     (mirror_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_all(input string tag);
    bit bad;
    bad = 1'b0;
    checks++;
    for (int k = 0; k < 8; k++) begin
      if (chr_page[k] !== PAGE_W'(exp_pg[k])) begin
        $display("FAIL %s slot %0d: actual %0d expected %0d", tag, k, chr_page[k], exp_pg[k]);
        bad = 1'b1;
      end
    end
    if (hi_ram_sel !== exp_hi) begin
      $display("FAIL %s ram flag: actual %0b expected %0b", tag, hi_ram_sel, exp_hi);
      bad = 1'b1;
    end
    if (mirror_mode !== 2'(exp_mir)) begin
      $display("FAIL %s mirroring: actual %0d expected %0d", tag, mirror_mode, exp_mir);
      bad = 1'b1;
    end
    if (bad) errors++;
  endtask

  // one register update, then compare on the following negative edge
  task automatic apply(input int sel, input int msel, input bit split,
                       input int r1, input int r2, input int cnt, input bit ram);
    string tag;
    @(negedge clk);
    upd_sel         = 2'(sel);
    ctrl_mirror_sel = 2'(msel);
    ctrl_split_chr  = split;
    lo_bank_reg     = REG_W'(r1);
    hi_bank_reg     = REG_W'(r2);
    chr_page_count  = (PAGE_W+1)'(cnt);
    chr_ram_mode    = ram;
    upd_valid       = 1'b1;
    @(negedge clk);
    upd_valid       = 1'b0;
    case (sel)
      0: begin
        tag = "R2";
        exp_mir = (msel == 3) ? 0 : (msel == 2) ? 1 : (msel == 1) ? 2 : 3;
      end
      1: begin
        if (ram)           tag = "R8";
        else if (cnt == 0) tag = "R9";
        else if (split)    tag = "R3";
        else               tag = "R4";
        if (!ram && cnt != 0) begin
          for (int k = 0; k < 8; k++)
            if (k < 4 || !split) exp_pg[k] = (r1 * 4 + k) % cnt;
          if (!split) exp_hi = 1'b0;
        end
      end
      2: begin
        if (!split)        tag = "R7";
        else if (ram)      tag = "R6";
        else if (cnt == 0) tag = "R9";
        else               tag = "R5";
        if (split) begin
          if (ram) begin
            for (int k = 0; k < 4; k++) exp_pg[4 + k] = r2 * 4 + k;
            exp_hi = 1'b1;
          end else if (cnt != 0) begin
            for (int k = 0; k < 4; k++) exp_pg[4 + k] = (r2 * 4 + k) % cnt;
            exp_hi = 1'b0;
          end
        end
      end
      default: tag = "R10";
    endcase
    check_all(tag);
  endtask

  initial begin
    int counts [8] = '{1, 3, 8, 16, 37, 128, 256, 0};
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; upd_valid = 1'b0; upd_sel = 2'd0; ctrl_mirror_sel = 2'd0;
    ctrl_split_chr = 1'b0; lo_bank_reg = '0; hi_bank_reg = '0;
    chr_page_count = '0; chr_ram_mode = 1'b0;
    for (int k = 0; k < 8; k++) exp_pg[k] = k;
    exp_hi = 1'b0; exp_mir = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: all four mirroring selections, twice in different orders
    for (int m = 0; m < 4; m++) apply(0, m, 1'b0, 0, 0, 8, 1'b0);
    for (int m = 3; m >= 0; m--) apply(0, m, 1'b1, 0, 0, 8, 1'b0);
    apply(0, 2, 1'b0, 0, 0, 8, 1'b0);

    // ROM sweeps: R3 R4 R5 R7 R9 over page counts and bank values
    foreach (counts[c]) begin
      for (int r = 0; r < 32; r++) begin
        for (int s = 0; s < 2; s++) begin
          apply(1, r & 3, s[0], r, 31 - r, counts[c], 1'b0);
          apply(2, r & 3, s[0], 31 - r, r, counts[c], 1'b0);
        end
      end
    end

    // RAM sweeps: R6 R7 R8
    for (int r = 0; r < 32; r++) begin
      for (int s = 0; s < 2; s++) begin
        apply(2, 0, s[0], r, r, 16, 1'b1);
        apply(1, 0, s[0], 31 - r, r, 16, 1'b1);
      end
    end

    // R4 clears the RAM flag after an R6 load
    apply(2, 0, 1'b1, 0, 9, 64, 1'b1);
    apply(1, 0, 1'b0, 5, 0, 64, 1'b0);

    // R10: index 3 pulses and idle cycles change nothing
    apply(3, 3, 1'b1, 17, 22, 5, 1'b0);
    apply(3, 0, 1'b0, 1, 2, 200, 1'b1);
    @(negedge clk);
    ctrl_mirror_sel = 2'd1; lo_bank_reg = 5'd30; chr_page_count = 9'd7;
    repeat (3) @(negedge clk);
    check_all("R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule